// File: doc/BRIEF.md
# Satellite Code Tracking Channel

This block is one tracking channel of a spread-spectrum satellite navigation receiver. It accepts packed 2-bit intermediate-frequency samples, steps a carrier oscillator and a code oscillator once for every sample, and correlates each sample against an 8-phase in-phase/quadrature local oscillator and two replicas of the ranging code. One replica is aligned with the code phase (prompt); the other is offset by half a chip, ahead or behind according to a select input (track arm).

Four running sums are kept: in-phase prompt, quadrature prompt, in-phase track and quadrature track. Each time the code oscillator completes one code period of 2046 half-chips, the four sums are transferred to output registers, a one-cycle strobe is raised, the sums restart, and any pending code slew is applied to the half-chip position. A tracking loop outside the block reads the four results on the strobe and steers the two oscillator increments and the slew.

Top module: `gps_track_channel`

## Requirements
- R1: A high `wordValid` loads `wordIn` (four 2-bit codes); on the next four clock cycles one code per cycle is consumed, bits [7:6] first and bits [1:0] last. A code v stands for the sample value 2v-3 (0 is -3, 1 is -1, 2 is +1, 3 is +3).
- R2: For each consumed sample the 32-bit carrier accumulator adds `carrierIncr`; when bit 27 of the sum is set, bits 31..27 are cleared and `carrierCycles` increments by one (modulo 2^16).
- R3: The oscillator phase p is bits 26..24 of the updated carrier accumulator. The in-phase value for p = 0..7 is +1,+2,+2,+1,-1,-2,-2,-1; the quadrature value at p is the in-phase value at (p+6) mod 8.
- R4: For each consumed sample the 32-bit code accumulator adds `codeIncr`; when bit 26 of the sum is set, bits 31..26 are cleared and the half-chip position h increments by one.
- R5: When h reaches 2046 the sample is a dump sample and h becomes 0; with `codeIncr` = 2^26 a dump happens every 2046 samples.
- R6: On the clock edge that consumes a dump sample, the four outputs take the sums accumulated over the samples before it and `dumpStrobe` is high for that one cycle; all four outputs hold their values at every other edge, and all outputs are zero after reset.
- R7: The dump sample's own contributions start the new sums.
- R8: The prompt chip is code chip h/2 (integer division). Chips come from a Gold generator: two 10-stage registers starting all ones, feedback taps 3,10 and 2,3,6,8,9,10; chip n is stage 10 of the first register XOR stages 2 and 6 (parameters) of the second, after n shifts. Chip bit 0 stands for +1 and 1 for -1.
- R9: With `lateSel` low the track chip is ((h+2047) mod 2046)/2 (early); with it high, ((h+2045) mod 2046)/2 (late).
- R10: A `slewWrite` pulse stores `slewValue` as pending; at the next dump h is set to the pending value modulo 2046 and the pending value returns to zero, so it acts on one dump only.
- R11: Clock cycles with no sample left to consume change neither oscillator, the position, the sums, the outputs nor `carrierCycles`.
- R12: Each sample adds s*I*P to I-prompt, s*Q*P to Q-prompt, s*I*T to I-track and s*Q*T to Q-track, where s is the sample, I/Q the oscillator values and P/T the prompt and track chips.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| wordValid | input | 1 | Load a new packed sample word |
| wordIn | input | 8 | Four 2-bit sample codes, highest pair first |
| carrierIncr | input | 32 | Carrier oscillator increment per sample |
| codeIncr | input | 32 | Code oscillator increment per sample |
| slewWrite | input | 1 | Store `slewValue` as the pending slew |
| slewValue | input | 11 | Half-chip slew applied at the next dump |
| lateSel | input | 1 | Track arm select: 0 early, 1 late |
| dumpStrobe | output | 1 | One-cycle pulse when the results update |
| dumpIPrompt | output | 24 | In-phase prompt sum, signed |
| dumpQPrompt | output | 24 | Quadrature prompt sum, signed |
| dumpITrack | output | 24 | In-phase track sum, signed |
| dumpQTrack | output | 24 | Quadrature track sum, signed |
| carrierCycles | output | 16 | Count of completed carrier cycles |

## Verification
A wrong half-chip position or a lost slew moves the dump instant, so the strobe arrives at the wrong sample and every result of that period and the next differs from the model; the fault is visible at the first dump after it, within one code period. A wrong oscillator phase, unpacking order or code chip changes the sums of the current period and shows at its dump, while a carrier counting error shows in `carrierCycles` at once. Sums that leak across a dump or move while no sample is consumed show as wrong values at the following dump.

// File: rtl/trk_pkg.sv
package trk_pkg;

  localparam int NCO_W         = 32;
  localparam int HALF_CHIPS    = 2046;
  localparam int CHIP_COUNT    = 1023;
  localparam int HALF_W        = 11;
  localparam int CHIP_W        = 10;
  localparam int CARR_WRAP_BIT = 27;
  localparam int CODE_WRAP_BIT = 26;
  localparam int PHASE_LSB     = 24;
  localparam int PHASE_W       = 3;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic valid;   // a sample is consumed this cycle
    logic dump;    // this sample ends a code period
  } trkStrobe_t;

  // Gold code of one satellite, chip n at bit n
  function automatic logic [CHIP_COUNT-1:0] goldCode(input int tapA, input int tapB);
    logic [10:1] regA;
    logic [10:1] regB;
    logic [CHIP_COUNT-1:0] chips;
    logic fbA;
    logic fbB;
    regA  = '1;
    regB  = '1;
    chips = '0;
    for (int n = 0; n < CHIP_COUNT; n++) begin
      chips[n] = regA[10] ^ regB[tapA] ^ regB[tapB];
      fbA  = regA[3] ^ regA[10];
      fbB  = regB[2] ^ regB[3] ^ regB[6] ^ regB[8] ^ regB[9] ^ regB[10];
      regA = {regA[9:1], fbA};
      regB = {regB[9:1], fbB};
    end
    return chips;
  endfunction

  // 8-phase in-phase oscillator table
  function automatic logic signed [2:0] iLut(input logic [PHASE_W-1:0] ph);
    case (ph)
      3'd0: return 3'sd1;
      3'd1: return 3'sd2;
      3'd2: return 3'sd2;
      3'd3: return 3'sd1;
      3'd4: return -3'sd1;
      3'd5: return -3'sd2;
      3'd6: return -3'sd2;
      default: return -3'sd1;
    endcase
  endfunction

endpackage

// File: rtl/trk_code_rom.sv
module trk_code_rom
  import trk_pkg::*;
#(
  parameter int TAP_A = 2,
  parameter int TAP_B = 6
) (
  input  logic [CHIP_W-1:0] chipIdx,
  output logic              chipBit
);
  localparam logic [CHIP_COUNT-1:0] CODE_TABLE = goldCode(TAP_A, TAP_B);

  always_comb begin
    chipBit = 1'b0;
    if (int'(chipIdx) < CHIP_COUNT) chipBit = CODE_TABLE[chipIdx];
  end
endmodule

// File: rtl/trk_ctrl.sv
module trk_ctrl
  import trk_pkg::*;
#(
  parameter int SAMPLES_PER_WORD = 4,
  parameter int CYC_W            = 16,
  localparam int WORD_W          = 2 * SAMPLES_PER_WORD,
  localparam int CNT_W           = $clog2(SAMPLES_PER_WORD + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wordValid,
  input  logic [WORD_W-1:0]  wordIn,
  input  logic [NCO_W-1:0]   carrierIncr,
  input  logic [NCO_W-1:0]   codeIncr,
  input  logic               slewWrite,
  input  logic [HALF_W-1:0]  slewValue,
  output trkStrobe_t         ctl,
  output logic [1:0]         sampleCode,
  output logic [PHASE_W-1:0] phaseIdx,
  output logic [HALF_W-1:0]  halfIdx,
  output logic [CYC_W-1:0]   carrierCycles
);
  logic [WORD_W-1:0] wordReg;
  logic [CNT_W-1:0]  remain;
  logic [CNT_W-1:0]  pairIdx;
  logic [NCO_W-1:0]  carrAcc, carrSum, carrNext;
  logic [NCO_W-1:0]  codeAcc, codeSum, codeNext;
  logic              carrWrap, codeWrap;
  logic [HALF_W-1:0] halfCnt, halfInc, slewPend, slewMod;
  logic              sampleValid, dumpNow;

  // ---- unpacker: highest pair first ----
  assign sampleValid = (remain != '0);
  assign pairIdx     = remain - 1'b1;

  always_comb begin
    sampleCode = 2'b00;
    for (int p = 0; p < SAMPLES_PER_WORD; p++) begin
      if (int'(pairIdx) == p) sampleCode = wordReg[2*p +: 2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wordReg <= '0;
      remain  <= '0;
    end else if (wordValid) begin
      wordReg <= wordIn;
      remain  <= CNT_W'(SAMPLES_PER_WORD);
    end else if (sampleValid) begin
      remain  <= remain - 1'b1;
    end
  end

  // ---- carrier oscillator ----
  assign carrSum  = carrAcc + carrierIncr;
  assign carrWrap = carrSum[CARR_WRAP_BIT];
  assign carrNext = carrWrap ? {{(NCO_W-CARR_WRAP_BIT){1'b0}}, carrSum[CARR_WRAP_BIT-1:0]} : carrSum;
  assign phaseIdx = carrNext[PHASE_LSB +: PHASE_W];

  // ---- code oscillator and half-chip position ----
  assign codeSum  = codeAcc + codeIncr;
  assign codeWrap = codeSum[CODE_WRAP_BIT];
  assign codeNext = codeWrap ? {{(NCO_W-CODE_WRAP_BIT){1'b0}}, codeSum[CODE_WRAP_BIT-1:0]} : codeSum;
  assign halfInc  = halfCnt + HALF_W'(codeWrap);
  assign dumpNow  = sampleValid && (halfInc == HALF_W'(HALF_CHIPS));
  assign halfIdx  = dumpNow ? '0 : halfInc;
  assign slewMod  = (slewPend >= HALF_W'(HALF_CHIPS)) ? slewPend - HALF_W'(HALF_CHIPS) : slewPend;

  assign ctl.valid = sampleValid;
  assign ctl.dump  = dumpNow;

  always_ff @(posedge clk) begin
    if (rst) begin
      carrAcc       <= '0;
      codeAcc       <= '0;
      halfCnt       <= '0;
      carrierCycles <= '0;
    end else if (sampleValid) begin
      carrAcc       <= carrNext;
      codeAcc       <= codeNext;
      halfCnt       <= dumpNow ? slewMod : halfInc;
      carrierCycles <= carrierCycles + CYC_W'(carrWrap);
    end
  end

  // ---- one-shot slew ----
  always_ff @(posedge clk) begin
    if (rst)            slewPend <= '0;
    else if (slewWrite) slewPend <= slewValue;
    else if (dumpNow)   slewPend <= '0;
  end

  // ---- assertions ----
  assert_half_range_R5: assert property (@(posedge clk) disable iff (rst)
    halfCnt < HALF_W'(HALF_CHIPS));

  assert_unpack_count_R1: assert property (@(posedge clk) disable iff (rst)
    int'(remain) <= SAMPLES_PER_WORD);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |=> $stable(carrAcc) && $stable(codeAcc) && $stable(halfCnt) && $stable(carrierCycles));

  assert_slew_oneshot_R10: assert property (@(posedge clk) disable iff (rst)
    (dumpNow && !slewWrite) |=> (slewPend == '0));

endmodule

// File: rtl/trk_datapath.sv
module trk_datapath
  import trk_pkg::*;
#(
  parameter int ACC_W = 24,
  parameter int TAP_A = 2,
  parameter int TAP_B = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  trkStrobe_t                  ctl,
  input  logic [1:0]                  sampleCode,
  input  logic [PHASE_W-1:0]          phaseIdx,
  input  logic [HALF_W-1:0]           halfIdx,
  input  logic                        lateSel,
  output logic                        dumpStrobe,
  output logic [3:0][ACC_W-1:0]       dumpBus
);
  localparam int NUM_SUMS = 4;
  localparam int NUM_ARMS = 2;
  localparam int PROD_W   = 6;

  logic signed [3:0]        sampleVal;
  logic signed [2:0]        loVal   [2];
  logic signed [PROD_W-1:0] loProd  [2];
  logic [HALF_W-1:0]        earlyH, lateH, trackH;
  logic [CHIP_W-1:0]        armIdx  [NUM_ARMS];
  logic                     armChip [NUM_ARMS];
  logic signed [PROD_W-1:0] term    [NUM_SUMS];
  logic signed [ACC_W-1:0]  accSum  [NUM_SUMS];
  logic signed [ACC_W-1:0]  outSum  [NUM_SUMS];

  // sample value 2v-3
  always_comb begin
    case (sampleCode)
      2'd0: sampleVal = -4'sd3;
      2'd1: sampleVal = -4'sd1;
      2'd2: sampleVal = 4'sd1;
      default: sampleVal = 4'sd3;
    endcase
  end

  // in-phase and quadrature oscillator values (quadrature two phases behind)
  assign loVal[0]  = iLut(phaseIdx);
  assign loVal[1]  = iLut(phaseIdx + 3'd6);
  assign loProd[0] = PROD_W'(sampleVal) * PROD_W'(loVal[0]);
  assign loProd[1] = PROD_W'(sampleVal) * PROD_W'(loVal[1]);

  // half-chip offsets for the track arm, wrapped inside one period
  assign earlyH = (halfIdx == HALF_W'(HALF_CHIPS - 1)) ? '0 : halfIdx + 1'b1;
  assign lateH  = (halfIdx == '0) ? HALF_W'(HALF_CHIPS - 1) : halfIdx - 1'b1;
  assign trackH = lateSel ? lateH : earlyH;

  assign armIdx[0] = halfIdx[HALF_W-1:1];
  assign armIdx[1] = trackH[HALF_W-1:1];

  for (genvar a = 0; a < NUM_ARMS; a++) begin : g_arm
    trk_code_rom #(.TAP_A(TAP_A), .TAP_B(TAP_B)) u_rom (
      .chipIdx(armIdx[a]),
      .chipBit(armChip[a])
    );
  end

  // sum k: oscillator k%2 (I/Q) times arm k/2 (prompt/track)
  for (genvar k = 0; k < NUM_SUMS; k++) begin : g_sum
    localparam int LO  = k % 2;
    localparam int ARM = k / 2;

    assign term[k] = armChip[ARM] ? -loProd[LO] : loProd[LO];

    always_ff @(posedge clk) begin
      if (rst) begin
        accSum[k] <= '0;
        outSum[k] <= '0;
      end else if (ctl.valid) begin
        accSum[k] <= (ctl.dump ? ACC_W'(0) : accSum[k]) + ACC_W'(term[k]);
        if (ctl.dump) outSum[k] <= accSum[k];
      end
    end

    assign dumpBus[k] = outSum[k];
  end

  always_ff @(posedge clk) begin
    if (rst) dumpStrobe <= 1'b0;
    else     dumpStrobe <= ctl.valid && ctl.dump;
  end

  // ---- assertions ----
  assert_strobe_source_R6: assert property (@(posedge clk) disable iff (rst)
    dumpStrobe |-> $past(ctl.valid && ctl.dump));

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !dumpStrobe |-> $stable(outSum[0]) && $stable(outSum[1]) && $stable(outSum[2]) && $stable(outSum[3]));

  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    dumpStrobe |-> (accSum[0] <= 6 && accSum[0] >= -6 && accSum[3] <= 6 && accSum[3] >= -6));

  assert_idle_sums_R11: assert property (@(posedge clk) disable iff (rst)
    !ctl.valid |=> $stable(accSum[0]) && $stable(accSum[2]));

endmodule

// File: rtl/gps_track_channel.sv
module gps_track_channel
  import trk_pkg::*;
#(
  parameter int ACC_W            = 24,
  parameter int CYC_W            = 16,
  parameter int SAMPLES_PER_WORD = 4,
  parameter int G2_TAP_A         = 2,
  parameter int G2_TAP_B         = 6,
  localparam int WORD_W          = 2 * SAMPLES_PER_WORD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordIn,
  input  logic [31:0]       carrierIncr,
  input  logic [31:0]       codeIncr,
  input  logic              slewWrite,
  input  logic [10:0]       slewValue,
  input  logic              lateSel,
  output logic              dumpStrobe,
  output logic [ACC_W-1:0]  dumpIPrompt,
  output logic [ACC_W-1:0]  dumpQPrompt,
  output logic [ACC_W-1:0]  dumpITrack,
  output logic [ACC_W-1:0]  dumpQTrack,
  output logic [CYC_W-1:0]  carrierCycles
);
  trkStrobe_t           ctl;
  logic [1:0]           sampleCode;
  logic [PHASE_W-1:0]   phaseIdx;
  logic [HALF_W-1:0]    halfIdx;
  logic [3:0][ACC_W-1:0] dumpBus;

  trk_ctrl #(.SAMPLES_PER_WORD(SAMPLES_PER_WORD), .CYC_W(CYC_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .wordValid(wordValid), .wordIn(wordIn),
    .carrierIncr(carrierIncr), .codeIncr(codeIncr),
    .slewWrite(slewWrite), .slewValue(slewValue),
    .ctl(ctl), .sampleCode(sampleCode), .phaseIdx(phaseIdx), .halfIdx(halfIdx),
    .carrierCycles(carrierCycles)
  );

  trk_datapath #(.ACC_W(ACC_W), .TAP_A(G2_TAP_A), .TAP_B(G2_TAP_B)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .sampleCode(sampleCode), .phaseIdx(phaseIdx), .halfIdx(halfIdx),
    .lateSel(lateSel), .dumpStrobe(dumpStrobe), .dumpBus(dumpBus)
  );

  assign dumpIPrompt = dumpBus[0];
  assign dumpQPrompt = dumpBus[1];
  assign dumpITrack  = dumpBus[2];
  assign dumpQTrack  = dumpBus[3];
endmodule

// File: tb/gps_track_channel_bench.sv
`timescale 1ns/1ps
module gps_track_channel_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wordValid = 1'b0;
  logic [7:0]  wordIn = '0;
  logic [31:0] carrierIncr = '0;
  logic [31:0] codeIncr = '0;
  logic        slewWrite = 1'b0;
  logic [10:0] slewValue = '0;
  logic        lateSel = 1'b0;
  logic        dumpStrobe;
  logic [23:0] dumpIPrompt, dumpQPrompt, dumpITrack, dumpQTrack;
  logic [15:0] carrierCycles;

  gps_track_channel u_gps_track_channel (
    .clk(clk), .rst(rst), .wordValid(wordValid), .wordIn(wordIn),
    .carrierIncr(carrierIncr), .codeIncr(codeIncr),
    .slewWrite(slewWrite), .slewValue(slewValue), .lateSel(lateSel),
    .dumpStrobe(dumpStrobe), .dumpIPrompt(dumpIPrompt), .dumpQPrompt(dumpQPrompt),
    .dumpITrack(dumpITrack), .dumpQTrack(dumpQTrack), .carrierCycles(carrierCycles)
  );

  always #2.5 clk = ~clk;

  typedef struct { int ip; int qp; int it; int qt; } expItem_t;
  expItem_t expQ[$];

  int checks = 0, errors = 0;
  int dumpsSeen = 0, dumpsMade = 0;
  int codeChip[1023];
  int iTab[8] = '{1, 2, 2, 1, -1, -2, -2, -1};
  bit [31:0] mCarr = 0, mCode = 0;
  int mHalf = 0, mPend = 0, mCyc = 0;
  int mSum[4] = '{0, 0, 0, 0};
  bit [15:0] lfsr = 16'hACE1;
  bit strobeSeenLast = 0;
  string scen = "R6 reset";

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // independent Gold code model (R8), chip +1/-1 values
  task automatic buildCode();
    int ra[11];
    int rb[11];
    int fa, fb;
    for (int j = 1; j <= 10; j++) begin ra[j] = 1; rb[j] = 1; end
    for (int n = 0; n < 1023; n++) begin
      codeChip[n] = ((ra[10] ^ rb[2] ^ rb[6]) != 0) ? -1 : 1;
      fa = ra[3] ^ ra[10];
      fb = rb[2] ^ rb[3] ^ rb[6] ^ rb[8] ^ rb[9] ^ rb[10];
      for (int j = 10; j >= 2; j--) begin ra[j] = ra[j-1]; rb[j] = rb[j-1]; end
      ra[1] = fa; rb[1] = fb;
    end
  endtask

  // reference model of one sample (R2..R5, R7, R9, R10, R12)
  task automatic modelSample(input int v);
    int s, ph, iv, qv, pc, tc;
    bit dumpHere;
    expItem_t item;
    s = 2 * v - 3;
    mCarr = mCarr + carrierIncr;
    if (mCarr[27]) begin mCarr[31:27] = 5'b0; mCyc++; end
    mCode = mCode + codeIncr;
    if (mCode[26]) begin mCode[31:26] = 6'b0; mHalf++; end
    dumpHere = (mHalf == 2046);
    if (dumpHere) mHalf = 0;
    ph = int'(mCarr[26:24]);
    iv = iTab[ph];
    qv = iTab[(ph + 6) % 8];
    pc = codeChip[mHalf / 2];
    tc = lateSel ? codeChip[((mHalf + 2045) % 2046) / 2] : codeChip[((mHalf + 2047) % 2046) / 2];
    if (dumpHere) begin
      item.ip = mSum[0]; item.qp = mSum[1]; item.it = mSum[2]; item.qt = mSum[3];
      expQ.push_back(item);
      dumpsMade++;
      for (int k = 0; k < 4; k++) mSum[k] = 0;
      mHalf = mPend % 2046;
      mPend = 0;
    end
    mSum[0] += s * iv * pc;
    mSum[1] += s * qv * pc;
    mSum[2] += s * iv * tc;
    mSum[3] += s * qv * tc;
  endtask

  // driver: one word every fourth cycle, model pushes expected dumps (R1)
  task automatic runWords(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wordValid = 1'b1;
      wordIn = lfsr[7:0];
      for (int k = 3; k >= 0; k--) modelSample(int'((lfsr[7:0] >> (2 * k)) & 8'h3));
      @(negedge clk);
      wordValid = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic writeSlew(input int v);
    @(negedge clk);
    slewWrite = 1'b1;
    slewValue = 11'(v);
    mPend = v;
    @(negedge clk);
    slewWrite = 1'b0;
  endtask

  // monitor: pop and compare on each strobe
  always @(negedge clk) begin
    if (!rst) begin
      if (strobeSeenLast) begin
        check(dumpStrobe == 1'b0, "R6 strobe lasts one cycle", int'(dumpStrobe), 0);
        strobeSeenLast = 0;
      end
      if (dumpStrobe) begin
        dumpsSeen++;
        strobeSeenLast = 1;
        if (expQ.size() == 0) begin
          check(1'b0, {scen, " R5 unexpected dump"}, dumpsSeen, dumpsMade);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(int'($signed(dumpIPrompt)) == e.ip, {scen, " R12 R1 R3 R7 R8 I-prompt"}, int'($signed(dumpIPrompt)), e.ip);
          check(int'($signed(dumpQPrompt)) == e.qp, {scen, " R12 R3 Q-prompt"}, int'($signed(dumpQPrompt)), e.qp);
          check(int'($signed(dumpITrack)) == e.it, {scen, " R12 R9 I-track"}, int'($signed(dumpITrack)), e.it);
          check(int'($signed(dumpQTrack)) == e.qt, {scen, " R12 R9 Q-track"}, int'($signed(dumpQTrack)), e.qt);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] holdI, holdQ;
    logic [15:0] holdCyc;
    int seenBefore;
    buildCode();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(dumpStrobe == 1'b0, "R6 reset strobe", int'(dumpStrobe), 0);
    check(dumpIPrompt == '0 && dumpQTrack == '0, "R6 reset outputs", int'(dumpIPrompt), 0);
    check(carrierCycles == '0, "R2 reset carrier count", int'(carrierCycles), 0);

    // A: one half-chip per sample, early arm
    scen = "R5 early";
    carrierIncr = 32'h0180_0000;
    codeIncr    = 32'h0400_0000;
    lateSel     = 1'b0;
    runWords(1100);
    check(int'(carrierCycles) == (mCyc % 65536), "R2 carrier cycles", int'(carrierCycles), mCyc % 65536);

    // idle: nothing moves (R11)
    holdI = dumpIPrompt; holdQ = dumpQTrack; holdCyc = carrierCycles; seenBefore = dumpsSeen;
    repeat (40) @(negedge clk);
    check(dumpIPrompt == holdI && dumpQTrack == holdQ, "R11 outputs held while idle", int'(dumpIPrompt), int'(holdI));
    check(carrierCycles == holdCyc, "R11 carrier count held while idle", int'(carrierCycles), int'(holdCyc));
    check(dumpsSeen == seenBefore, "R11 no dump while idle", dumpsSeen, seenBefore);

    // B: slew 100 then late arm, odd carrier step
    scen = "R10 slew late";
    writeSlew(100);
    lateSel     = 1'b1;
    carrierIncr = 32'h0123_4567;
    runWords(1100);
    check(int'(carrierCycles) == (mCyc % 65536), "R2 carrier cycles after slew", int'(carrierCycles), mCyc % 65536);

    // C: slew above period wraps, half-chip every second sample
    scen = "R10 slew wrap R4";
    writeSlew(2047);
    lateSel  = 1'b0;
    codeIncr = 32'h0200_0000;
    runWords(2100);

    // D: irregular code step
    scen = "R4 irregular step";
    codeIncr    = 32'h0300_0000;
    carrierIncr = 32'h07ff_ffff;
    lateSel     = 1'b1;
    runWords(700);
    check(int'(carrierCycles) == (mCyc % 65536), "R2 carrier cycles final", int'(carrierCycles), mCyc % 65536);

    check(dumpsSeen == dumpsMade, "R5 dump count", dumpsSeen, dumpsMade);
    check(expQ.size() == 0, "R5 all expected dumps seen", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule